// File: doc/BRIEF.md
# Add/Subtract Reservation Station Group

This block holds up to three pending add or subtract operations in front of one shared, pipelined arithmetic unit. Each operation arrives with, for each of its two operands, either a ready value or a nonzero producer tag that names the station that will deliver the value later. A free station accepts the operation at once, even when an operand is still missing. While it waits, the station watches the result broadcast bus. When the tag on the bus matches a missing operand, the station copies the value from the bus.

A station whose two operands are present asks to enter the shared pipeline. One station enters per cycle, and the lowest-numbered candidate goes first. When the fixed-latency pipeline returns a result, the owning station holds it and asks to drive the result bus with its own tag. An arbiter outside the block answers that request with a grant. The arithmetic itself is a placeholder: a wrapping integer add or subtract.

Top module: `add_rs_group`

## Requirements
- R1: While reset is held and in the cycle after it, every station is free (`st_busy` = 000), `iss_ready` is 1 and `res_req` is 0.
- R2: An operation offered with `iss_valid` while `iss_ready` is 1 goes into the lowest-numbered free station, and that station's `st_busy` bit (bit 0 = first station) is set after the edge. `iss_ready` is 0 while all three stations are busy, and an offer made then is dropped: no station changes and no result ever appears for it.
- R3: With `iss_op` = 0 the result is Vj+Vk, and with `iss_op` = 1 it is Vj−Vk, both modulo 2^32. The result is broadcast with `res_tag` = 4'b1011, 4'b1100 or 4'b1101 for stations 0, 1 and 2.
- R4: A nonzero operand tag makes the station wait until `cdb_valid` is high with `cdb_tag` equal to that tag, and the station then takes `cdb_data` as the operand. A broadcast with any other tag leaves the station waiting and produces no result.
- R5: A matching broadcast in the same cycle as the issue is captured at issue, so the operation runs with no further broadcast.
- R6: Stations whose operands become complete in the same cycle enter the pipeline one per cycle, lowest-numbered first, and their results reach the bus in that order.
- R7: An operation issued with both operands ready at clock edge k raises `res_req` after edge k+PIPE_LAT+1 (edge k+4 by default).
- R8: While `res_req` is high and `res_grant` is low, `res_req`, `res_tag` and `res_data` hold their values. The station offered when `res_grant` is high is free after the next edge.
- R9: When the bus is not already committed to an offer and several stations hold results, the lowest-numbered one is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation offered for issue |
| iss_op | input | 1 | 0 = add, 1 = subtract |
| iss_vj | input | 32 | First operand value, used when `iss_qj` is 0 |
| iss_qj | input | 4 | First operand producer tag; 0 means the value is ready |
| iss_vk | input | 32 | Second operand value, used when `iss_qk` is 0 |
| iss_qk | input | 4 | Second operand producer tag; 0 means the value is ready |
| iss_ready | output | 1 | At least one station is free |
| cdb_valid | input | 1 | Result bus carries a value this cycle |
| cdb_tag | input | 4 | Tag of the producer on the result bus |
| cdb_data | input | 32 | Value on the result bus |
| st_busy | output | 3 | Busy bit of each station |
| res_req | output | 1 | A station asks to broadcast its result |
| res_grant | input | 1 | The result bus is granted to the offered station |
| res_tag | output | 4 | Tag of the offered station |
| res_data | output | 32 | Result of the offered station |

## Verification
An issue can land in the same cycle as a bus broadcast that carries the tag of the operand being issued. The bench provokes this on purpose in a directed case, and the random phase also produces it often. It is judged by the result value that comes out at the normal latency with no later broadcast. Completion and offer can also collide. A later station finishes while an earlier offer is held without a grant, and several stations become ready at one edge. These cases are judged by the order and the stability of the tags seen on the result port.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int RS_DW   = 32;
    localparam int RS_TW   = 4;
    localparam int RS_NUM  = 3;
    localparam int RS_LAT  = 3;
    localparam int RS_IW   = (RS_NUM > 1) ? $clog2(RS_NUM) : 1;
    localparam logic [RS_TW-1:0] RS_BASE = 4'b1011;

    typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    typedef struct packed {
        op_e              op;
        logic [RS_DW-1:0] vj;
        logic [RS_TW-1:0] qj;
        logic [RS_DW-1:0] vk;
        logic [RS_TW-1:0] qk;
    } iss_t;

    function automatic logic [RS_DW-1:0] rs_calc(op_e op, logic [RS_DW-1:0] a,
                                                 logic [RS_DW-1:0] b);
        return (op == OP_SUB) ? a - b : a + b;
    endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rs_pipe.sv
module rs_pipe import rs_pkg::*; #(
    parameter int LAT = RS_LAT,
    parameter int IW  = RS_IW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  op_e              in_op,
    input  logic [RS_DW-1:0] in_a,
    input  logic [RS_DW-1:0] in_b,
    input  logic [IW-1:0]    in_idx,
    output logic             out_vld,
    output logic [IW-1:0]    out_idx,
    output logic [RS_DW-1:0] out_data
);
    logic [LAT-1:0]   vld_q;
    logic [IW-1:0]    idx_q [LAT];
    logic [RS_DW-1:0] dat_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_vld;
            for (int s = 1; s < LAT; s++) vld_q[s] <= vld_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        idx_q[0] <= in_idx;
        dat_q[0] <= rs_calc(in_op, in_a, in_b);
        for (int s = 1; s < LAT; s++) begin
            idx_q[s] <= idx_q[s-1];
            dat_q[s] <= dat_q[s-1];
        end
    end

    assign out_vld  = vld_q[LAT-1];
    assign out_idx  = idx_q[LAT-1];
    assign out_data = dat_q[LAT-1];
endmodule

// File: rtl/rs_station.sv
module rs_station import rs_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_en,
    input  iss_t             iss,
    input  logic             cdb_vld,
    input  logic [RS_TW-1:0] cdb_tag,
    input  logic [RS_DW-1:0] cdb_data,
    input  logic             disp_gnt,
    input  logic             ret_hit,
    input  logic [RS_DW-1:0] ret_data,
    input  logic             bus_gnt,
    output logic             busy,
    output logic             rdy,
    output logic             done,
    output op_e              op_o,
    output logic [RS_DW-1:0] vj_o,
    output logic [RS_DW-1:0] vk_o,
    output logic [RS_DW-1:0] res_o
);
    st_e              state;
    op_e              op_q;
    logic [RS_DW-1:0] vj_q, vk_q, res_q;
    logic [RS_TW-1:0] qj_q, qk_q;

    logic hit_iss_j, hit_iss_k, hit_j, hit_k;
    assign hit_iss_j = cdb_vld && (iss.qj != '0) && (cdb_tag == iss.qj);
    assign hit_iss_k = cdb_vld && (iss.qk != '0) && (cdb_tag == iss.qk);
    assign hit_j     = cdb_vld && (qj_q != '0) && (cdb_tag == qj_q);
    assign hit_k     = cdb_vld && (qk_q != '0) && (cdb_tag == qk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FREE;
            qj_q  <= '0;
            qk_q  <= '0;
        end else begin
            case (state)
                ST_FREE: if (issue_en) begin
                    state <= ST_WAIT;
                    op_q  <= iss.op;
                    qj_q  <= hit_iss_j ? '0 : iss.qj;
                    vj_q  <= hit_iss_j ? cdb_data : iss.vj;
                    qk_q  <= hit_iss_k ? '0 : iss.qk;
                    vk_q  <= hit_iss_k ? cdb_data : iss.vk;
                end
                ST_WAIT: begin
                    if (disp_gnt) state <= ST_EXEC;
                    if (hit_j) begin
                        vj_q <= cdb_data;
                        qj_q <= '0;
                    end
                    if (hit_k) begin
                        vk_q <= cdb_data;
                        qk_q <= '0;
                    end
                end
                ST_EXEC: if (ret_hit) begin
                    res_q <= ret_data;
                    state <= ST_DONE;
                end
                ST_DONE: if (bus_gnt) state <= ST_FREE;
                default: state <= ST_FREE;
            endcase
        end
    end

    assign busy  = (state != ST_FREE);
    assign rdy   = (state == ST_WAIT) && (qj_q == '0) && (qk_q == '0);
    assign done  = (state == ST_DONE);
    assign op_o  = op_q;
    assign vj_o  = vj_q;
    assign vk_o  = vk_q;
    assign res_o = res_q;
endmodule

// File: rtl/add_rs_group.sv
module add_rs_group import rs_pkg::*; #(
    parameter int NUM_ST   = RS_NUM,
    parameter int PIPE_LAT = RS_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic             iss_op,
    input  logic [RS_DW-1:0] iss_vj,
    input  logic [RS_TW-1:0] iss_qj,
    input  logic [RS_DW-1:0] iss_vk,
    input  logic [RS_TW-1:0] iss_qk,
    output logic             iss_ready,
    input  logic             cdb_valid,
    input  logic [RS_TW-1:0] cdb_tag,
    input  logic [RS_DW-1:0] cdb_data,
    output logic [NUM_ST-1:0] st_busy,
    output logic             res_req,
    input  logic             res_grant,
    output logic [RS_TW-1:0] res_tag,
    output logic [RS_DW-1:0] res_data
);
    localparam int IW = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;

    iss_t iss_pkt;
    assign iss_pkt = '{op: op_e'(iss_op), vj: iss_vj, qj: iss_qj, vk: iss_vk, qk: iss_qk};

    logic [NUM_ST-1:0] busy_v, rdy_v, done_v;
    logic [NUM_ST-1:0] issue_en, disp_gnt, ret_hit, bus_gnt;
    op_e              op_a  [NUM_ST];
    logic [RS_DW-1:0] vj_a  [NUM_ST];
    logic [RS_DW-1:0] vk_a  [NUM_ST];
    logic [RS_DW-1:0] res_a [NUM_ST];

    logic          free_any, disp_any, done_any;
    logic [IW-1:0] free_idx, disp_idx, done_idx, sel_idx;
    logic          pipe_vld;
    logic [IW-1:0] pipe_idx;
    logic [RS_DW-1:0] pipe_data;
    logic          hold_vld;
    logic [IW-1:0] hold_idx;

    rs_pick #(.N(NUM_ST), .IW(IW)) u_free (.req(~busy_v), .any(free_any), .idx(free_idx));
    rs_pick #(.N(NUM_ST), .IW(IW)) u_disp (.req(rdy_v),   .any(disp_any), .idx(disp_idx));
    rs_pick #(.N(NUM_ST), .IW(IW)) u_done (.req(done_v),  .any(done_any), .idx(done_idx));

    assign sel_idx = hold_vld ? hold_idx : done_idx;

    for (genvar i = 0; i < NUM_ST; i++) begin : g_st
        assign issue_en[i] = iss_valid && free_any && (free_idx == IW'(i));
        assign disp_gnt[i] = disp_any && (disp_idx == IW'(i));
        assign ret_hit[i]  = pipe_vld && (pipe_idx == IW'(i));
        assign bus_gnt[i]  = res_grant && res_req && (sel_idx == IW'(i));

        rs_station u_st (
            .clk      (clk),
            .rst      (rst),
            .issue_en (issue_en[i]),
            .iss      (iss_pkt),
            .cdb_vld  (cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_data (cdb_data),
            .disp_gnt (disp_gnt[i]),
            .ret_hit  (ret_hit[i]),
            .ret_data (pipe_data),
            .bus_gnt  (bus_gnt[i]),
            .busy     (busy_v[i]),
            .rdy      (rdy_v[i]),
            .done     (done_v[i]),
            .op_o     (op_a[i]),
            .vj_o     (vj_a[i]),
            .vk_o     (vk_a[i]),
            .res_o    (res_a[i])
        );
    end

    rs_pipe #(.LAT(PIPE_LAT), .IW(IW)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (disp_any),
        .in_op    (op_a[disp_idx]),
        .in_a     (vj_a[disp_idx]),
        .in_b     (vk_a[disp_idx]),
        .in_idx   (disp_idx),
        .out_vld  (pipe_vld),
        .out_idx  (pipe_idx),
        .out_data (pipe_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_idx <= '0;
        end else if (res_req && !res_grant) begin
            hold_vld <= 1'b1;
            hold_idx <= sel_idx;
        end else if (res_grant) begin
            hold_vld <= 1'b0;
        end
    end

    assign iss_ready = free_any;
    assign st_busy   = busy_v;
    assign res_req   = hold_vld || done_any;
    assign res_tag   = RS_BASE + RS_TW'(sel_idx);
    assign res_data  = res_a[sel_idx];
endmodule

// File: rtl/add_rs_group_chk.sv
module add_rs_group_chk import rs_pkg::*; #(
    parameter int NUM_ST = RS_NUM
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [NUM_ST-1:0] st_busy,
    input logic              res_req,
    input logic              res_grant,
    input logic [RS_TW-1:0]  res_tag,
    input logic [RS_DW-1:0]  res_data
);
    localparam int IW = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;
    logic [RS_TW-1:0] tag_off;
    logic [IW-1:0]    gnt_idx;
    assign tag_off = res_tag - RS_BASE;
    assign gnt_idx = tag_off[IW-1:0];

    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (st_busy == '0 && !res_req));

    // R2
    p_issue_fills_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !(res_req && res_grant)) |=>
        ($countones(st_busy) == $countones($past(st_busy)) + 1));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (&st_busy && !(res_req && res_grant)) |=> (&st_busy));

    // R3
    p_tag_range_r3: assert property (@(posedge clk) disable iff (rst)
        res_req |-> (res_tag >= RS_BASE && res_tag < RS_BASE + RS_TW'(NUM_ST)));

    // R8
    p_offer_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (res_req && !res_grant) |=> (res_req && $stable(res_tag) && $stable(res_data)));

    p_grant_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (res_req && res_grant) |=> !st_busy[$past(gnt_idx)]);

    p_offer_busy_r8: assert property (@(posedge clk) disable iff (rst)
        res_req |-> st_busy[gnt_idx]);
endmodule

bind add_rs_group add_rs_group_chk #(.NUM_ST(NUM_ST)) chk_i (.*);

// File: tb/add_rs_group_tb_top.sv
`timescale 1ns/1ps
module add_rs_group_tb_top;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             iss_valid = 0, iss_op = 0;
    logic [RS_DW-1:0] iss_vj = 0, iss_vk = 0;
    logic [RS_TW-1:0] iss_qj = 0, iss_qk = 0;
    logic             iss_ready;
    logic             cdb_valid = 0;
    logic [RS_TW-1:0] cdb_tag = 0;
    logic [RS_DW-1:0] cdb_data = 0;
    logic [2:0]       st_busy;
    logic             res_req, res_grant = 0;
    logic [RS_TW-1:0] res_tag;
    logic [RS_DW-1:0] res_data;

    add_rs_group dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
        .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_ready(iss_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .st_busy(st_busy), .res_req(res_req), .res_grant(res_grant),
        .res_tag(res_tag), .res_data(res_data)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic logic [RS_DW-1:0] ref_calc(logic op, logic [RS_DW-1:0] a,
                                                  logic [RS_DW-1:0] b);
        return op ? a - b : a + b;
    endfunction

    task automatic issue(input logic op, input logic [RS_DW-1:0] vj, input logic [RS_TW-1:0] qj,
                         input logic [RS_DW-1:0] vk, input logic [RS_TW-1:0] qk);
        iss_valid = 1; iss_op = op; iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
        cyc();
        iss_valid = 0;
    endtask

    task automatic expect_req(input logic exp_req, input logic [RS_TW-1:0] tag,
                              input logic [RS_DW-1:0] data, input string req);
        chk(res_req == exp_req, req, res_req, exp_req);
        if (exp_req) begin
            chk(res_tag == tag, req, res_tag, tag);
            chk(res_data == data, req, res_data, data);
        end
    endtask

    // bench model of station contents, for the random phase
    logic             m_busy [3];
    logic             m_op   [3];
    logic [RS_DW-1:0] m_vj [3], m_vk [3];
    logic [RS_TW-1:0] m_qj [3], m_qk [3];
    int n_iss = 0, n_res = 0;

    task automatic rand_cycle(input int grant_pct, input bit force_bc, input logic [RS_TW-1:0] fbt);
        logic g, bv, iv;
        logic [RS_TW-1:0] bt;
        logic [RS_DW-1:0] bd;
        logic [1:0] idx;
        logic op;
        logic [RS_DW-1:0] vj, vk;
        logic [RS_TW-1:0] qj, qk;
        int t;
        g = res_req && (($urandom % 100) < grant_pct);
        if (g) begin
            idx = 2'(res_tag - RS_BASE);
            chk(m_busy[idx], "R3 offered station holds work", 0, 1);
            chk(res_data == ref_calc(m_op[idx], m_vj[idx], m_vk[idx]), "R3 random result",
                res_data, ref_calc(m_op[idx], m_vj[idx], m_vk[idx]));
            m_busy[idx] = 0;
            n_res++;
        end
        bv = force_bc ? 1'b1 : 1'($urandom % 2);
        bt = force_bc ? fbt : RS_TW'(1 + $urandom % 10);
        bd = $urandom;
        for (int j = 0; j < 3; j++) begin
            if (m_busy[j] && bv && m_qj[j] == bt) begin m_vj[j] = bd; m_qj[j] = 0; end
            if (m_busy[j] && bv && m_qk[j] == bt) begin m_vk[j] = bd; m_qk[j] = 0; end
        end
        iv = ($urandom % 3) != 0;
        op = 1'($urandom % 2);
        vj = $urandom; vk = $urandom;
        qj = ($urandom % 2) ? RS_TW'(1 + $urandom % 10) : '0;
        qk = ($urandom % 2) ? RS_TW'(1 + $urandom % 10) : '0;
        if (iv && iss_ready) begin
            t = -1;
            for (int j = 2; j >= 0; j--) if (!st_busy[j]) t = j;
            if (t >= 0) begin
                m_busy[t] = 1; m_op[t] = op;
                m_vj[t] = (qj != 0 && bv && bt == qj) ? bd : vj;
                m_qj[t] = (qj != 0 && bv && bt == qj) ? '0 : qj;
                m_vk[t] = (qk != 0 && bv && bt == qk) ? bd : vk;
                m_qk[t] = (qk != 0 && bv && bt == qk) ? '0 : qk;
                n_iss++;
            end
        end
        res_grant = g;
        cdb_valid = bv; cdb_tag = bt; cdb_data = bd;
        iss_valid = iv; iss_op = op; iss_vj = vj; iss_vk = vk; iss_qj = qj; iss_qk = qk;
        cyc();
        res_grant = 0; cdb_valid = 0; iss_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0021));
        repeat (3) cyc();
        // R1: reset state while held
        chk(st_busy == 3'b000, "R1 busy in reset", st_busy, 0);
        chk(iss_ready == 1'b1, "R1 ready in reset", iss_ready, 1);
        chk(res_req == 1'b0, "R1 req in reset", res_req, 0);
        rst = 0;
        cyc();
        chk(st_busy == 3'b000 && !res_req, "R1 idle after reset", {st_busy, res_req}, 0);

        // R7 R3 R2: ready add, latency
        issue(0, 32'd5, 0, 32'd7, 0);
        chk(st_busy == 3'b001, "R2 lowest free station", st_busy, 3'b001);
        for (int c = 1; c <= 3; c++) begin
            cyc();
            chk(res_req == 0, "R7 no early request", res_req, 0);
        end
        cyc();
        expect_req(1, 4'b1011, 32'd12, "R7 R3 add result");
        repeat (2) cyc();
        expect_req(1, 4'b1011, 32'd12, "R8 offer held without grant");
        res_grant = 1; cyc(); res_grant = 0;
        chk(st_busy == 3'b000 && !res_req, "R8 freed after grant", {st_busy, res_req}, 0);

        // R3: subtract wraps
        issue(1, 32'd3, 0, 32'd5, 0);
        repeat (4) cyc();
        expect_req(1, 4'b1011, 32'hFFFF_FFFE, "R3 sub wrap");
        res_grant = 1; cyc(); res_grant = 0;

        // R2 R4 R6: fill, drop when full, wrong tag, then one broadcast wakes all
        for (int i = 0; i < 3; i++) issue(0, 32'd0, 4'b0011, 32'(i + 1), 0);
        chk(st_busy == 3'b111, "R2 all busy", st_busy, 3'b111);
        chk(iss_ready == 0, "R2 ready low when full", iss_ready, 0);
        issue(0, 32'd9, 0, 32'd9, 0);
        chk(st_busy == 3'b111, "R2 full issue dropped", st_busy, 3'b111);
        cdb_valid = 1; cdb_tag = 4'b0100; cdb_data = 32'd50; cyc(); cdb_valid = 0;
        repeat (6) cyc();
        chk(res_req == 0, "R4 unmatched tag ignored", res_req, 0);
        res_grant = 1;
        cdb_valid = 1; cdb_tag = 4'b0011; cdb_data = 32'd100; cyc(); cdb_valid = 0;
        for (int c = 1; c <= 3; c++) begin
            cyc();
            chk(res_req == 0, "R6 pipeline fill", res_req, 0);
        end
        cyc(); expect_req(1, 4'b1011, 32'd101, "R6 R4 first station");
        cyc(); expect_req(1, 4'b1100, 32'd102, "R6 second station");
        cyc(); expect_req(1, 4'b1101, 32'd103, "R6 third station");
        cyc();
        res_grant = 0;
        chk(st_busy == 3'b000 && !res_req, "R2 dropped issue left no work", {st_busy, res_req}, 0);

        // R5: broadcast in the issue cycle
        cdb_valid = 1; cdb_tag = 4'b0101; cdb_data = 32'd100;
        issue(0, 32'd0, 4'b0101, 32'd1, 0);
        cdb_valid = 0;
        repeat (3) cyc();
        chk(res_req == 0, "R5 latency", res_req, 0);
        cyc();
        expect_req(1, 4'b1011, 32'd101, "R5 capture at issue");
        res_grant = 1; cyc(); res_grant = 0;

        // R8 R9: later station holds the bus, then lowest first
        issue(0, 32'd0, 4'b0110, 32'd10, 0);
        issue(0, 32'd0, 4'b0110, 32'd20, 0);
        issue(1, 32'd50, 0, 32'd8, 0);
        repeat (6) cyc();
        expect_req(1, 4'b1101, 32'd42, "R8 first finisher offered");
        cdb_valid = 1; cdb_tag = 4'b0110; cdb_data = 32'd1000; cyc(); cdb_valid = 0;
        repeat (8) cyc();
        expect_req(1, 4'b1101, 32'd42, "R8 offer stable while others finish");
        res_grant = 1; cyc(); res_grant = 0;
        expect_req(1, 4'b1011, 32'd1010, "R9 lowest offered next");
        res_grant = 1; cyc(); res_grant = 0;
        expect_req(1, 4'b1100, 32'd1020, "R9 then next station");
        res_grant = 1; cyc(); res_grant = 0;
        chk(st_busy == 3'b000, "R8 all freed", st_busy, 0);

        // random phase: R3 R4 R5 values against the bench model
        for (int j = 0; j < 3; j++) m_busy[j] = 0;
        for (int c = 0; c < 3000; c++) rand_cycle(70, 0, '0);
        for (int c = 0; c < 200; c++) rand_cycle(100, 1, RS_TW'(1 + c % 10));
        chk(n_iss >= n_res && n_iss - n_res <= 3, "R2 issue count", n_res, n_iss);
        for (int c = 0; c < 40; c++) begin
            res_grant = 1;
            cdb_valid = 1; cdb_tag = RS_TW'(1 + c % 10); cdb_data = 0;
            if (res_req) begin
                n_res++;
                for (int j = 0; j < 3; j++) if (res_tag == RS_BASE + RS_TW'(j)) m_busy[j] = 0;
            end
            cyc();
        end
        res_grant = 0; cdb_valid = 0;
        chk(n_iss == n_res, "R2 every issued op produced one result", n_res, n_iss);
        chk(st_busy == 3'b000, "R8 drained", st_busy, 0);

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule